// File: doc/BRIEF.md
# Card Data FIFO With Status Flags

This block holds the data words that move between a host register port and a memory-card data path. It has two independent word queues. The transmit queue is filled by host writes and drained by the card side. The receive queue is filled by the card side and drained by host reads. The host side moves only whole 32-bit words. A transfer whose byte count is not a multiple of four is rounded up to whole words before it reaches this block. The card side uses a single-cycle push or pop strobe, and the head word of each queue is always visible on its read port.

A packed 32-bit status word reports the level of each queue: empty, full, data available, and a half-depth watermark. Software can therefore move half a queue or a whole queue per status check. Two sticky error bits record a receive overrun and a transmit underrun. Each error bit is cleared by writing a one at its own bit position through a clear strobe. A count output tells the host how many receive words are waiting.

Each queue is tracked by a three-state occupancy machine with the states LN_EMPTY, LN_PART and LN_FULL. An accepted push moves LN_EMPTY to LN_PART, or LN_PART to LN_FULL when the last slot fills. An accepted pop moves LN_FULL to LN_PART, or LN_PART to LN_EMPTY when the last word leaves. A push and a pop accepted together keep the current state. The depth is a power-of-two parameter: 16 words by default, with an extended setting of 128 words.

Top module: `card_fifo_core`

## Requirements
- R1: After reset both queues are empty, `rx_count` is 0, and `status` equals 32'h000C4000 (bits 14, 18 and 19 set). Every status bit not named in R4 to R10 always reads 0.
- R2: Words written with `host_wr_en` leave through `card_tx_data` in write order. Each `card_tx_pop` on a non-empty transmit queue advances the head by one word.
- R3: Words pushed with `card_rx_push` appear on `host_rdata` in push order. Each `host_rd_en` on a non-empty receive queue advances the head by one word.
- R4: A host write to a full transmit queue without a same-cycle card pop is dropped, and the queue contents are unchanged.
- R5: A card push to a full receive queue without a same-cycle host read drops the word and sets sticky bit 5 (receive overrun) in the next cycle.
- R6: A card pop from an empty transmit queue while `xfer_active` is 1 sets sticky bit 4 (transmit underrun) in the next cycle. When `xfer_active` is 0, the same pop sets nothing. A pop from an empty queue never changes the queue.
- R7: A `clr_wr_en` cycle clears bit 5 when `clr_wdata[5]` is 1 and clears bit 4 when `clr_wdata[4]` is 1. Zero bits in `clr_wdata` leave the flags unchanged. A set event in the same cycle takes priority over the clear.
- R8: Status bit 14 is 1 when transmit occupancy is at or below DEPTH/2. Status bit 15 is 1 when receive occupancy is at or above DEPTH/2.
- R9: Status bits 16 and 17 are the transmit-full and receive-full flags. Bits 18 and 19 are the transmit-empty and receive-empty flags.
- R10: Status bits 20 and 21 are 1 when the transmit or receive queue, respectively, holds at least one word.
- R11: `rx_count` equals the number of words in the receive queue.
- R12: On a full queue, a push and a pop in the same cycle are both accepted and the occupancy stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host writes one word into the transmit queue |
| host_wdata | input | 32 | Host write word |
| host_rd_en | input | 1 | Host takes one word from the receive queue |
| host_rdata | output | 32 | Head word of the receive queue |
| clr_wr_en | input | 1 | Strobe for the error clear word |
| clr_wdata | input | 32 | Clear word; a one at bit 4 or 5 clears that flag |
| xfer_active | input | 1 | A card transfer is in progress (qualifies underrun) |
| status | output | 32 | Packed level and error flags |
| rx_count | output | $clog2(DEPTH+1) | Words waiting in the receive queue |
| card_tx_pop | input | 1 | Card side takes one transmit word |
| card_tx_data | output | 32 | Head word of the transmit queue |
| card_rx_push | input | 1 | Card side delivers one receive word |
| card_rx_data | input | 32 | Receive word from the card side |

## Verification
The assertions assume that the strobes are clean single-cycle levels. They do not assume that any strobe is withheld from a full or empty queue: pushes to full queues, pops from empty queues and clears that coincide with set events are all legal. The stimulus covers these cases deliberately, in directed fill, overfill, drain and overdrain sequences. A long random phase then toggles every strobe independently, together with random clear words and a random `xfer_active`. The result is that every assertion antecedent, including the same-cycle push-and-pop on a full queue, is reached many times.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;
    typedef enum logic [1:0] {
        LN_EMPTY = 2'd0,
        LN_PART  = 2'd1,
        LN_FULL  = 2'd2
    } lane_state_t;

    localparam int ST_TX_UNDERRUN  = 4;
    localparam int ST_RX_OVERRUN   = 5;
    localparam int ST_TX_HALF_EMPT = 14;
    localparam int ST_RX_HALF_FULL = 15;
    localparam int ST_TX_FULL      = 16;
    localparam int ST_RX_FULL      = 17;
    localparam int ST_TX_EMPTY     = 18;
    localparam int ST_RX_EMPTY     = 19;
    localparam int ST_TX_AVAIL     = 20;
    localparam int ST_RX_AVAIL     = 21;
endpackage

// File: rtl/card_fifo_lane.sv
module card_fifo_lane
    import card_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             push_drop,
    output logic             pop_miss
);
    lane_state_t      state_q, state_d;
    logic [CW-1:0]    count_q, count_d;
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             pop_ok, push_ok;

    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign count_d = count_q + CW'(push_ok) - CW'(pop_ok);

    always_comb begin
        if (count_d == '0)
            state_d = LN_EMPTY;
        else if (count_d == CW'(DEPTH))
            state_d = LN_FULL;
        else
            state_d = LN_PART;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_EMPTY;
            count_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            LN_EMPTY: empty = 1'b1;
            LN_PART:  ;
            LN_FULL:  full  = 1'b1;
            default:  ;
        endcase
    end

    assign dout      = mem[rd_ptr];
    assign count     = count_q;
    assign push_drop = push && full && !pop_ok;
    assign pop_miss  = pop && empty;
endmodule

// File: rtl/card_fifo_status.sv
module card_fifo_status
    import card_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic          tx_empty,
    input  logic          tx_full,
    input  logic          rx_empty,
    input  logic          rx_full,
    input  logic          ovr_set,
    input  logic          und_set,
    input  logic          clr_en,
    input  logic          clr_ovr,
    input  logic          clr_und,
    output logic [31:0]   status
);
    logic ovr_q, und_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else begin
            if (ovr_set)                 ovr_q <= 1'b1;
            else if (clr_en && clr_ovr)  ovr_q <= 1'b0;
            if (und_set)                 und_q <= 1'b1;
            else if (clr_en && clr_und)  und_q <= 1'b0;
        end
    end

    always_comb begin
        status                  = '0;
        status[ST_TX_UNDERRUN]  = und_q;
        status[ST_RX_OVERRUN]   = ovr_q;
        status[ST_TX_HALF_EMPT] = (tx_count <= CW'(HALF));
        status[ST_RX_HALF_FULL] = (rx_count >= CW'(HALF));
        status[ST_TX_FULL]      = tx_full;
        status[ST_RX_FULL]      = rx_full;
        status[ST_TX_EMPTY]     = tx_empty;
        status[ST_RX_EMPTY]     = rx_empty;
        status[ST_TX_AVAIL]     = (tx_count != '0);
        status[ST_RX_AVAIL]     = (rx_count != '0);
    end
endmodule

// File: rtl/card_fifo_core.sv
module card_fifo_core
    import card_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_en,
    input  logic [31:0]   host_wdata,
    input  logic          host_rd_en,
    output logic [31:0]   host_rdata,
    input  logic          clr_wr_en,
    input  logic [31:0]   clr_wdata,
    input  logic          xfer_active,
    output logic [31:0]   status,
    output logic [CW-1:0] rx_count,
    input  logic          card_tx_pop,
    output logic [31:0]   card_tx_data,
    input  logic          card_rx_push,
    input  logic [31:0]   card_rx_data
);
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic tx_drop, tx_miss, rx_drop, rx_miss;
    logic unused_clr_bits;

    assign unused_clr_bits = ^{clr_wdata[31:6], clr_wdata[3:0], tx_drop, rx_miss};

    card_fifo_lane #(.DEPTH(DEPTH), .WIDTH(32)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .push(host_wr_en), .din(host_wdata),
        .pop(card_tx_pop), .dout(card_tx_data),
        .count(tx_cnt), .empty(tx_empty), .full(tx_full),
        .push_drop(tx_drop), .pop_miss(tx_miss)
    );

    card_fifo_lane #(.DEPTH(DEPTH), .WIDTH(32)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push(card_rx_push), .din(card_rx_data),
        .pop(host_rd_en), .dout(host_rdata),
        .count(rx_cnt), .empty(rx_empty), .full(rx_full),
        .push_drop(rx_drop), .pop_miss(rx_miss)
    );

    card_fifo_status #(.DEPTH(DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .tx_count(tx_cnt), .rx_count(rx_cnt),
        .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_empty(rx_empty), .rx_full(rx_full),
        .ovr_set(rx_drop), .und_set(tx_miss && xfer_active),
        .clr_en(clr_wr_en),
        .clr_ovr(clr_wdata[ST_RX_OVERRUN]), .clr_und(clr_wdata[ST_TX_UNDERRUN]),
        .status(status)
    );

    assign rx_count = rx_cnt;
endmodule

// File: rtl/card_fifo_core_chk.sv
module card_fifo_core_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr_en,
    input logic          host_rd_en,
    input logic          card_tx_pop,
    input logic          card_rx_push,
    input logic          xfer_active,
    input logic          clr_wr_en,
    input logic [31:0]   clr_wdata,
    input logic [31:0]   status,
    input logic [CW-1:0] rx_count
);
    p_tx_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[16] && host_wr_en && !card_tx_pop |=> status[16]);

    p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status[17] && card_rx_push && !host_rd_en |=> status[5]);

    p_underrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status[18] && card_tx_pop && xfer_active |=> status[4]);

    p_quiet_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !status[4] && !(card_tx_pop && xfer_active) |=> !status[4]);

    p_overrun_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_en && clr_wdata[5] && !(status[17] && card_rx_push && !host_rd_en)
        |=> !status[5]);

    p_full_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[17] |-> status[15] && !status[16] || status[17] && status[15]);

    p_tx_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[16] && status[18]) && !(status[17] && status[19]));

    p_rx_avail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status[21] == !status[19]);

    p_rx_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(DEPTH)) == status[17]);

    p_full_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status[17] && card_rx_push && host_rd_en |=> status[17]);
endmodule

bind card_fifo_core card_fifo_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .card_tx_pop(card_tx_pop), .card_rx_push(card_rx_push),
    .xfer_active(xfer_active),
    .clr_wr_en(clr_wr_en), .clr_wdata(clr_wdata),
    .status(status), .rx_count(rx_count)
);

// File: tb/card_fifo_core_test.sv
module card_fifo_core_test;
    localparam int D  = 16;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [31:0]   host_wdata = '0, host_rdata;
    logic          clr_wr_en = 1'b0;
    logic [31:0]   clr_wdata = '0;
    logic          xfer_active = 1'b0;
    logic [31:0]   status;
    logic [CW-1:0] rx_count;
    logic          card_tx_pop = 1'b0, card_rx_push = 1'b0;
    logic [31:0]   card_tx_data, card_rx_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    bit ovr = 0, und = 0;

    always #4 clk = ~clk;

    card_fifo_core #(.DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .host_rd_en(host_rd_en), .host_rdata(host_rdata),
        .clr_wr_en(clr_wr_en), .clr_wdata(clr_wdata),
        .xfer_active(xfer_active),
        .status(status), .rx_count(rx_count),
        .card_tx_pop(card_tx_pop), .card_tx_data(card_tx_data),
        .card_rx_push(card_rx_push), .card_rx_data(card_rx_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit tx_pop_ok, tx_push_ok, rx_pop_ok, rx_push_ok, und_set, ovr_set;
        tx_pop_ok  = card_tx_pop && txq.size() > 0;
        und_set    = card_tx_pop && txq.size() == 0 && xfer_active;
        tx_push_ok = host_wr_en && (txq.size() < D || tx_pop_ok);
        rx_pop_ok  = host_rd_en && rxq.size() > 0;
        rx_push_ok = card_rx_push && (rxq.size() < D || rx_pop_ok);
        ovr_set    = card_rx_push && rxq.size() == D && !rx_pop_ok;
        if (tx_pop_ok)  void'(txq.pop_front());
        if (tx_push_ok) txq.push_back(host_wdata);
        if (rx_pop_ok)  void'(rxq.pop_front());
        if (rx_push_ok) rxq.push_back(card_rx_data);
        if (ovr_set) ovr = 1;
        else if (clr_wr_en && clr_wdata[5]) ovr = 0;
        if (und_set) und = 1;
        else if (clr_wr_en && clr_wdata[4]) und = 0;
    endtask

    task automatic compare();
        int tn = txq.size();
        int rn = rxq.size();
        logic [31:0] rest;
        rest = status & ~32'h003FC030;
        chk(rest == 0, "R1 unused bits", rest, 0);
        chk(status[5] == ovr, "R5 R7 overrun", {31'd0, status[5]}, {31'd0, ovr});
        chk(status[4] == und, "R6 R7 underrun", {31'd0, status[4]}, {31'd0, und});
        chk(status[14] == (tn <= D/2), "R8 tx half-empty", {31'd0, status[14]}, tn);
        chk(status[15] == (rn >= D/2), "R8 rx half-full", {31'd0, status[15]}, rn);
        chk(status[16] == (tn == D) && status[18] == (tn == 0), "R9 tx full/empty",
            status, tn);
        chk(status[17] == (rn == D) && status[19] == (rn == 0), "R9 rx full/empty",
            status, rn);
        chk(status[20] == (tn != 0) && status[21] == (rn != 0), "R10 avail", status, tn + rn);
        chk(int'(rx_count) == rn, "R11 rx_count", 32'(rx_count), rn);
        if (tn > 0) chk(card_tx_data == txq[0], "R2 tx head", card_tx_data, txq[0]);
        if (rn > 0) chk(host_rdata == rxq[0], "R3 rx head", host_rdata, rxq[0]);
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        host_wr_en = 0; host_rd_en = 0; card_tx_pop = 0; card_rx_push = 0;
        clr_wr_en = 0; clr_wdata = '0;
    endtask

    initial begin
        #(8 * 60000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 32'h000C4000, "R1 reset status", status, 32'h000C4000);
        chk(rx_count == 0, "R1 reset rx_count", 32'(rx_count), 0);
        compare();

        // R2: short write then pop sequence
        for (int i = 0; i < 3; i++) begin
            idle(); host_wr_en = 1; host_wdata = 32'hA000_0000 + i; step();
        end
        for (int i = 0; i < 3; i++) begin
            idle(); card_tx_pop = 1; xfer_active = 1; step();
        end

        // R4: fill transmit queue and overfill
        for (int i = 0; i < D + 2; i++) begin
            idle(); host_wr_en = 1; host_wdata = 32'hB100_0000 + i; step();
        end
        chk(status[16], "R4 tx stays full", status, 32'h1 << 16);
        // R12: write and pop together on a full queue
        idle(); host_wr_en = 1; card_tx_pop = 1; host_wdata = 32'hC0DE_0001; step();
        chk(status[16], "R12 tx full after paired ops", status, 32'h1 << 16);
        // drain the transmit queue, then pop once more with a transfer active
        for (int i = 0; i < D; i++) begin
            idle(); card_tx_pop = 1; step();
        end
        chk(status[18] && !status[4], "R4 exactly DEPTH words held", status, 32'h1 << 18);
        idle(); card_tx_pop = 1; xfer_active = 1; step();
        chk(status[4], "R6 underrun set", status, 32'h10);
        // R7: clear with zero bit leaves flag
        idle(); clr_wr_en = 1; clr_wdata = 32'hFFFF_FFEF; step();
        chk(status[4], "R7 zero bit keeps flag", status, 32'h10);
        idle(); clr_wr_en = 1; clr_wdata = 32'h10; step();
        chk(!status[4], "R7 underrun cleared", status, 0);
        // R6: no flag when no transfer is active
        idle(); card_tx_pop = 1; xfer_active = 0; step();
        chk(!status[4], "R6 idle pop no flag", status, 0);

        // R5: fill receive queue and overrun
        for (int i = 0; i < D + 1; i++) begin
            idle(); card_rx_push = 1; card_rx_data = 32'hD200_0000 + i; step();
        end
        chk(status[5] && rx_count == CW'(D), "R5 overrun and drop", status, 32'h20);
        idle(); clr_wr_en = 1; clr_wdata = 32'h20; step();
        chk(!status[5], "R7 overrun cleared", status, 0);
        // R7: set and clear in the same cycle, set wins
        idle(); card_rx_push = 1; card_rx_data = 32'hEEEE_0001;
        clr_wr_en = 1; clr_wdata = 32'h20; step();
        chk(status[5], "R7 set beats clear", status, 32'h20);
        // R12: push and read together on a full receive queue
        idle(); card_rx_push = 1; host_rd_en = 1; card_rx_data = 32'hF00D_0002; step();
        chk(rx_count == CW'(D), "R12 rx stays full", 32'(rx_count), D);
        for (int i = 0; i < D; i++) begin
            idle(); host_rd_en = 1; step();
        end
        chk(rx_count == 0, "R3 drained", 32'(rx_count), 0);

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            idle();
            host_wr_en   = ($urandom_range(0, 3) != 0);
            host_wdata   = $urandom;
            card_tx_pop  = ($urandom_range(0, 3) != 0);
            card_rx_push = ($urandom_range(0, 3) != 0);
            card_rx_data = $urandom;
            host_rd_en   = ($urandom_range(0, 3) != 0);
            xfer_active  = $urandom_range(0, 1);
            clr_wr_en    = ($urandom_range(0, 7) == 0);
            clr_wdata    = $urandom;
            step();
        end
        idle();
        step();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule